// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received frame is kept, based only on its 48-bit destination address. Upstream logic presents the address with a one-cycle strobe. One cycle later the block returns a verdict: accept or drop. When the frame is accepted it also says whether the hit came from an exact-match entry or from the multicast hash table and broadcast path.

Two structures hold the filter state. The first is a bank of 16 exact-match entries. Entry 0 is meant for the station's own unicast address, and the other entries hold extra addresses. The second is a 4096-bit multicast hash table. A 2-bit setting picks which 12-bit window of the upper address bytes indexes this table. Software programs both structures through a simple word-wide register write port and reads them back through a registered read port. A separate enable controls whether the all-ones broadcast address is accepted.

In this document, address bits are numbered so that byte 0 (the first byte on the wire) occupies bits 7:0 and byte 5 occupies bits 47:40.

Top module: `daf_filter`

## Requirements
- R1: After reset, every entry's valid bit is clear and every hash word is zero. Every register reads as 0, and `res_valid`, `res_accept` and `res_exact` are 0.
- R2: A valid exact entry whose 48 stored bits equal the destination address causes `res_accept`=1 and `res_exact`=1.
- R3: An entry whose valid bit is clear never matches. Writing a high word with bit 31 clear disables that entry.
- R4: Register addresses 0x00..0x1F hold the exact entries. Entry i uses address 2i for its low word and 2i+1 for its high word. The low word holds byte 0 in bits 7:0 up to byte 3 in bits 31:24. The high word holds byte 4 in bits 7:0, byte 5 in bits 15:8, and the valid bit in bit 31.
- R5: Hash word w sits at register address 0x80+w, for w from 0 to 127. A 12-bit hash h selects word h[11:5] and bit h[4:0] within that word.
- R6: The hash is taken from a window of the address chosen by `hash_sel`. Select 0 uses bits 47:36, select 1 uses 46:35, select 2 uses 45:34, and select 3 uses 43:32.
- R7: The hash table applies only to multicast addresses, meaning bit 0 of byte 0 is 1. A multicast address whose hash bit is 1 gives `res_accept`=1 and `res_exact`=0. A unicast address is never accepted through the hash.
- R8: The all-ones address is accepted if and only if `bcast_en`=1, whatever the table contents. When it is accepted, `res_exact`=0.
- R9: `res_valid` is 1 exactly in the cycle after a cycle with `da_valid`=1. When `res_valid` is 0, both `res_accept` and `res_exact` are 0.
- R10: `reg_rdata` returns, one cycle after `reg_addr` is presented, the stored word at that address. High-word bits 30:16 read as 0. Unmapped addresses read as 0.
- R11: When an exact entry and the hash bit both match a multicast address, `res_exact`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| hash_sel | input | 2 | Hash window select |
| bcast_en | input | 1 | Accept the all-ones address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_exact | output | 1 | Accepted through an exact entry |

## Verification
The bench uses the following address patterns, and each one separates a different source of a verdict:
- Addresses copied from programmed entries show whether the exact comparison covers all 48 bits and honours the valid bit.
- Random multicast addresses, looked up under all four hash selects, catch a window that is shifted by one bit or an index that swaps the word and bit fields.
- Unicast addresses whose hash bit is set expose a filter that ignores the multicast bit.
- The all-ones address, tried with the enable both on and off, checks the broadcast override.
- Addresses that match both an exact entry and the hash table check which source is reported.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int DA_W     = 48;
  localparam int WORD_W   = 32;
  localparam int HASH_W   = 12;
  localparam int BIT_IW   = $clog2(WORD_W);
  localparam int HASH_WRD = (1 << HASH_W) / WORD_W;

  // Pick the 12-bit hash window from the two top address bytes.
  function automatic logic [HASH_W-1:0] hash_pick(input logic [DA_W-1:0] da,
                                                  input logic [1:0] sel);
    logic [HASH_W-1:0] h;
    case (sel)
      2'd0:    h = da[47:36];
      2'd1:    h = da[46:35];
      2'd2:    h = da[45:34];
      default: h = da[43:32];
    endcase
    return h;
  endfunction
endpackage

// File: rtl/daf_exact_bank.sv
module daf_exact_bank #(
  parameter int N_ENTRY = 16,
  parameter int IW      = $clog2(2 * N_ENTRY)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [31:0]              wr_data,
  input  logic [IW-1:0]            rd_idx,
  output logic [31:0]              rd_data,
  input  logic [daf_pkg::DA_W-1:0] da,
  output logic                     hit
);
  logic [N_ENTRY-1:0] hit_vec;
  logic [31:0]        word_lo [N_ENTRY];
  logic [31:0]        word_hi [N_ENTRY];

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    logic        vld_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q  <= '0;
        hi_q  <= '0;
        vld_q <= 1'b0;
      end else if (wr_en) begin
        if (wr_idx == IW'(2 * e)) begin
          lo_q <= wr_data;
        end
        if (wr_idx == IW'(2 * e + 1)) begin
          hi_q  <= wr_data[15:0];
          vld_q <= wr_data[31];
        end
      end
    end

    assign hit_vec[e] = vld_q && (lo_q == da[31:0]) && (hi_q == da[47:32]);
    assign word_lo[e] = lo_q;
    assign word_hi[e] = {vld_q, 15'd0, hi_q};
  end

  assign hit     = |hit_vec;
  assign rd_data = rd_idx[0] ? word_hi[rd_idx[IW-1:1]] : word_lo[rd_idx[IW-1:1]];
endmodule

// File: rtl/daf_hash_bank.sv
module daf_hash_bank #(
  parameter int WORDS = daf_pkg::HASH_WRD,
  parameter int IW    = $clog2(WORDS),
  parameter int HW    = IW + daf_pkg::BIT_IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_data,
  input  logic [HW-1:0] hash,
  output logic          bit_set
);
  localparam int BW = daf_pkg::BIT_IW;

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
  assign bit_set = mem[hash[HW-1:BW]][hash[BW-1:0]];
endmodule

// File: rtl/daf_filter.sv
module daf_filter #(
  parameter int N_EXACT = 16,
  parameter int REG_AW  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     da_valid,
  input  logic [daf_pkg::DA_W-1:0] da_addr,
  input  logic [1:0]               hash_sel,
  input  logic                     bcast_en,
  input  logic                     reg_wr,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic                     res_valid,
  output logic                     res_accept,
  output logic                     res_exact
);
  import daf_pkg::*;

  localparam int EX_WORDS = 2 * N_EXACT;
  localparam int EX_IW    = $clog2(EX_WORDS);
  localparam int HS_IW    = $clog2(HASH_WRD);

  // Region decode: top address bit selects the hash table.
  logic in_hash, in_exact;
  assign in_hash  = reg_addr[REG_AW-1];
  assign in_exact = !reg_addr[REG_AW-1] &&
                    ({1'b0, reg_addr[REG_AW-2:0]} < REG_AW'(EX_WORDS));

  logic [31:0] ex_rd, hs_rd;
  logic        ex_hit, hs_bit;
  logic [HASH_W-1:0] hash_val;

  assign hash_val = hash_pick(da_addr, hash_sel);

  daf_exact_bank #(.N_ENTRY(N_EXACT), .IW(EX_IW)) u_exact (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr && in_exact),
    .wr_idx (reg_addr[EX_IW-1:0]),
    .wr_data(reg_wdata),
    .rd_idx (reg_addr[EX_IW-1:0]),
    .rd_data(ex_rd),
    .da     (da_addr),
    .hit    (ex_hit)
  );

  daf_hash_bank #(.WORDS(HASH_WRD), .IW(HS_IW), .HW(HASH_W)) u_hash (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr && in_hash),
    .wr_idx (reg_addr[HS_IW-1:0]),
    .wr_data(reg_wdata),
    .rd_idx (reg_addr[HS_IW-1:0]),
    .rd_data(hs_rd),
    .hash   (hash_val),
    .bit_set(hs_bit)
  );

  // Verdict: broadcast override, then exact, then multicast hash.
  logic is_mc, is_bc, acc_d, exact_d;
  always_comb begin
    is_mc   = da_addr[0];
    is_bc   = &da_addr;
    acc_d   = 1'b0;
    exact_d = 1'b0;
    if (is_bc) begin
      acc_d = bcast_en;
    end else if (ex_hit) begin
      acc_d   = 1'b1;
      exact_d = 1'b1;
    end else if (is_mc && hs_bit) begin
      acc_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_exact  <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      res_valid  <= da_valid;
      res_accept <= da_valid && acc_d;
      res_exact  <= da_valid && exact_d;
      reg_rdata  <= in_hash ? hs_rd : (in_exact ? ex_rd : 32'd0);
    end
  end
endmodule

// File: rtl/daf_filter_chk.sv
module daf_filter_chk (
  input logic        clk,
  input logic        rst,
  input logic        da_valid,
  input logic [47:0] da_addr,
  input logic        bcast_en,
  input logic        res_valid,
  input logic        res_accept,
  input logic        res_exact
);
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(da_valid)); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_accept && !res_exact)); // R9
  AST_EXACT_IMPLIES_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    res_exact |-> res_accept); // R2
  AST_UNICAST_NO_HASH: assert property (@(posedge clk) disable iff (rst)
    (res_accept && !res_exact) |-> $past(da_addr[0])); // R7
  AST_BCAST_GATED: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(&da_addr)) |-> (res_accept == $past(bcast_en))); // R8
  AST_BCAST_NOT_EXACT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(&da_addr)) |-> !res_exact); // R8
endmodule

bind daf_filter daf_filter_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .da_valid  (da_valid),
  .da_addr   (da_addr),
  .bcast_en  (bcast_en),
  .res_valid (res_valid),
  .res_accept(res_accept),
  .res_exact (res_exact)
);

// File: tb/daf_filter_bench.sv
module daf_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic [1:0]  hash_sel = '0;
  logic        bcast_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        res_valid, res_accept, res_exact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_lo   [16];
  logic [31:0] m_hi   [16];
  logic [31:0] m_hash [128];

  always #(CLK_PERIOD / 2) clk = ~clk;

  daf_filter u_daf_filter (
    .clk(clk), .rst(rst), .da_valid(da_valid), .da_addr(da_addr),
    .hash_sel(hash_sel), .bcast_en(bcast_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .res_valid(res_valid), .res_accept(res_accept), .res_exact(res_exact)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Hash built from byte arithmetic (byte 4 and byte 5).
  function automatic int ref_hash(input logic [47:0] da, input logic [1:0] sel);
    int b4, b5;
    b4 = int'(da[39:32]);
    b5 = int'(da[47:40]);
    case (sel)
      2'd0: return ((b4 >> 4) | (b5 << 4)) & 12'hFFF;
      2'd1: return ((b4 >> 3) | (b5 << 5)) & 12'hFFF;
      2'd2: return ((b4 >> 2) | (b5 << 6)) & 12'hFFF;
      default: return (b4 | (b5 << 8)) & 12'hFFF;
    endcase
  endfunction

  function automatic logic [1:0] ref_verdict(input logic [47:0] da, input logic [1:0] sel,
                                             input logic ben);
    bit ex = 1'b0;
    int h;
    if (da == {48{1'b1}}) return {ben, 1'b0};
    for (int i = 0; i < 16; i++)
      if (m_hi[i][31] && m_lo[i] == da[31:0] && m_hi[i][15:0] == da[47:32]) ex = 1'b1;
    if (ex) return 2'b11;
    h = ref_hash(da, sel);
    if (da[0] && m_hash[h / 32][h % 32]) return 2'b10;
    return 2'b00;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a < 8'h20) begin
      if (a[0]) m_hi[a[4:1]] = {d[31], 15'd0, d[15:0]};
      else      m_lo[a[4:1]] = d;
    end else if (a[7]) begin
      m_hash[a[6:0]] = d;
    end
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic lookup(input string req, input logic [47:0] da, input logic [1:0] sel,
                        input logic ben);
    logic [1:0] e;
    e = ref_verdict(da, sel, ben);
    da_addr = da; hash_sel = sel; bcast_en = ben; da_valid = 1'b1;
    @(negedge clk);
    da_valid = 1'b0;
    check({req, " valid"}, {31'd0, res_valid}, 32'd1);
    check(req, {30'd0, res_accept, res_exact}, {30'd0, e});
  endtask

  task automatic set_entry(input int i, input logic [47:0] mac, input logic vld);
    wr(8'(2 * i), mac[31:0]);
    wr(8'(2 * i + 1), {vld, 15'd0, mac[47:32]});
  endtask

  initial begin
    int seed_dummy;
    logic [47:0] da;
    seed_dummy = $urandom(32'h5EED_0A11);
    for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    for (int i = 0; i < 128; i++) m_hash[i] = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 outputs", {29'd0, res_valid, res_accept, res_exact}, 32'd0);
    rd_check("R1 entry hi", 8'h01, 32'd0);
    rd_check("R1 hash word", 8'hFF, 32'd0);
    lookup("R1 zero addr rejected", 48'h0, 2'd0, 1'b0);

    // R2 R4: entry 3 holds bytes 11 22 33 44 55 66
    set_entry(3, 48'h665544332211, 1'b1);
    lookup("R2 exact hit", 48'h665544332211, 2'd0, 1'b0);
    rd_check("R4 low word", 8'h06, 32'h44332211);
    lookup("R2 one bit off", 48'h665544332210, 2'd0, 1'b0);

    // R10: unused high bits read zero; unmapped reads zero
    wr(8'h07, 32'hFFFF_6655);
    rd_check("R10 hi mask", 8'h07, 32'h8000_6655);
    rd_check("R10 unmapped", 8'h40, 32'd0);

    // R3: clearing valid disables entry
    wr(8'h07, 32'h0000_6655);
    lookup("R3 invalid entry", 48'h665544332211, 2'd0, 1'b0);

    // R5 R6: hash 0xB53 -> word 0x5A bit 19, under select 3
    wr(8'h80 + 8'h5A, 32'h1 << 19);
    rd_check("R5 hash readback", 8'hDA, 32'h0008_0000);
    lookup("R5 hash hit sel3", 48'h0B53_0000_0001, 2'd3, 1'b0);
    lookup("R5 neighbour bit", 48'h0B52_0000_0001, 2'd3, 1'b0);
    lookup("R6 sel0 window", {12'hB53, 36'h0_0000_0001}, 2'd0, 1'b0);
    lookup("R6 sel1 window", {1'b0, 12'hB53, 35'h0_0000_0001}, 2'd1, 1'b0);
    lookup("R6 sel2 window", {2'b0, 12'hB53, 34'h0_0000_0001}, 2'd2, 1'b0);

    // R7: unicast with hash bit set rejected
    lookup("R7 unicast hash", 48'h0B53_0000_0000, 2'd3, 1'b0);

    // R11: exact and hash both match
    set_entry(9, 48'h0B53_0000_0001, 1'b1);
    lookup("R11 exact wins", 48'h0B53_0000_0001, 2'd3, 1'b0);

    // R8: broadcast, also with an all-ones exact entry
    set_entry(5, {48{1'b1}}, 1'b1);
    lookup("R8 bcast off", {48{1'b1}}, 2'd0, 1'b0);
    lookup("R8 bcast on", {48{1'b1}}, 2'd0, 1'b1);

    // R9: no strobe, no verdict
    @(negedge clk);
    check("R9 idle", {29'd0, res_valid, res_accept, res_exact}, 32'd0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      k = int'($urandom % 8);
      if (k == 0) begin
        set_entry(int'($urandom % 16), {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF,
                  1'($urandom % 4 != 0));
      end else if (k == 1) begin
        wr(8'h80 | 8'($urandom % 128), $urandom);
      end else if (k == 2) begin
        int i;
        i = int'($urandom % 16);
        rd_check("R10 random readback hi", 8'(2 * i + 1), m_hi[i]);
      end else begin
        int i;
        i = int'($urandom % 16);
        case ($urandom % 3)
          0: da = {m_hi[i][15:0], m_lo[i]};
          1: da = {16'($urandom), $urandom} | 48'h1;
          default: da = {16'($urandom), $urandom};
        endcase
        lookup("R2 R7 random lookup", da, 2'($urandom), 1'($urandom));
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG_LIMIT; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule